// File: doc/BRIEF.md
# Reset Generator with Restart-Cause Capture

This block merges every reset request in a chip into three reset domains and remembers which event caused the last restart. The power-on domain covers the CPU and all of its debug logic. The system domain covers the CPU alone, so a running debug session survives. The third domain covers only the debug access port.

The requests are:
- a core or memory supply-failure flag and an active-low external reset pin, both asynchronous;
- a watchdog expiry, a software reset request and an option-byte check failure, all synchronous;
- a deep-sleep hold from the power manager, qualified by a low-voltage power-good flag;
- a reset request from the debug side.

The always-on supply failure is the block's own asynchronous reset. A CPU lockup flag is stored as a cause but starts no reset.

Asynchronous sources assert their domains at once. They are released through a two-flop synchroniser, and every output is then stretched by a counter. The cause register lives in the always-on domain. Software reads it through a one-cycle read port.

Top module: `rstgen_top`

## Requirements
- R1: While `aon_rst_n` is low, all three reset outputs are low and `rd_data` is 0. After release, the cause reads 0x01, which is bit 0, the always-on supply failure.
- R2: `core_fail` high, or `ext_rst_n` low, drives `por_rst_n`, `sys_rst_n` and `dap_rst_n` low before the next clock edge.
- R3: A pulse on `wdog_expire`, `sw_rst_req` or `optbyte_fail` drives `sys_rst_n` low and leaves `por_rst_n` and `dap_rst_n` high.
- R4: An output rises STRETCH (16) edges after the last edge that sampled its request. For an asynchronous source, two more synchroniser edges come first, so the output rises 18 edges after the source drops.
- R5: `dap_rst_req` drives only `dap_rst_n` low.
- R6: The cause bits are: 1 core supply, 2 pin, 3 watchdog, 4 software, 5 deep-sleep wake, 6 option-byte failure, 7 CPU lockup. A rising request clears the earlier cause and sets only its own bit.
- R7: When requests rise in the same cycle, the lowest bit number among 1 to 5 wins. The option-byte failure (bit 6) ranks below those, and lockup (bit 7) is last.
- R8: An option-byte failure with no higher request sets bit 6 and keeps all other bits.
- R9: A rising `cpu_lockup` sets the cause to 0x80 and asserts no reset output.
- R10: `sys_rst_n` stays low from the first cycle `dsleep_hold` is high until `dsleep_hold` is low and `lv_pwr_good` is high, and is then stretched per R4.
- R11: In emulated sleep `lv_pwr_good` stays high, so `sys_rst_n` rises 17 edges after `dsleep_hold` drops.
- R12: `rd_en` high at an edge loads the cause into `rd_data`. Otherwise `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| aon_rst_n | input | 1 | Always-on supply good; low marks an always-on supply failure |
| core_fail | input | 1 | Core or memory supply failure, asynchronous, active high |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| wdog_expire | input | 1 | Watchdog expiry, synchronous |
| sw_rst_req | input | 1 | Software reset request, synchronous |
| optbyte_fail | input | 1 | Option-byte check failure, synchronous |
| cpu_lockup | input | 1 | CPU lockup indication, recorded only |
| dsleep_hold | input | 1 | Deep-sleep hold from the power manager |
| lv_pwr_good | input | 1 | Low-voltage power-good after wake |
| dap_rst_req | input | 1 | Debug access port reset request |
| rd_en | input | 1 | Cause register read strobe |
| por_rst_n | output | 1 | Power-on domain reset (CPU and debug), active low |
| sys_rst_n | output | 1 | System domain reset (CPU only), active low |
| dap_rst_n | output | 1 | Debug access port reset, active low |
| rd_data | output | 8 | Cause value captured by the last read |

## Verification
Synchronous requests are due on the reset outputs and in the cause register at the edge that first samples them. Asynchronous sources pull the outputs low within the same cycle, and their cause bit follows at the next edge. Releases come 16, 17 or 18 edges after the source drops, depending on the source, and read data appears one edge after `rd_en`. A bench model advances at each rising edge and is compared at each falling edge. Stimulus changes just after the falling edge, and the fixed-latency checks count falling edges from that point.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int NCAUSE = 8;
  localparam int C_AON  = 0;
  localparam int C_CORE = 1;
  localparam int C_PIN  = 2;
  localparam int C_WDOG = 3;
  localparam int C_SW   = 4;
  localparam int C_WAKE = 5;
  localparam int C_OPT  = 6;
  localparam int C_LOCK = 7;
  localparam int NDOM   = 3;
  localparam int D_POR  = 0;
  localparam int D_SYS  = 1;
  localparam int D_DAP  = 2;
  typedef logic [NCAUSE-1:0] cause_t;
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic req_s
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b0};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '1;
    else         sh_q <= sh_d;
  end

  assign req_s = sh_q[STAGES-1];

  // R4
  sync_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(req_s) |-> !$past(sh_q[0]));
endmodule

// File: rtl/rstgen_stretch.sv
module rstgen_stretch #(
  parameter int STRETCH = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  output logic rst_n
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LIM = CW'(STRETCH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = req || (cnt_q != LIM);
    cnt_d  = req ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign rst_n = (cnt_q == LIM);

  // R4
  req_asserts_chk: assert property (@(posedge clk) disable iff (!arst_n)
    req |=> !rst_n);
  // R4
  stays_released_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rst_n && !req |=> rst_n || req);
endmodule

// File: rtl/rstgen_cause.sv
module rstgen_cause
  import rstgen_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t lvl,
  input  logic   rd_en,
  output cause_t rd_data
);
  cause_t prev_q;
  cause_t cause_q;
  cause_t cause_d;
  cause_t rd_q;
  cause_t rise;
  cause_t win;
  logic   found;
  logic   cause_en;

  always_comb begin
    rise  = lvl & ~prev_q;
    win   = '0;
    found = 1'b0;
    for (int i = C_CORE; i <= C_WAKE; i++) begin
      if (rise[i] && !found) begin
        win[i] = 1'b1;
        found  = 1'b1;
      end
    end
    if (found)             cause_d = win;
    else if (rise[C_OPT])  cause_d = cause_q | (cause_t'(1) << C_OPT);
    else if (rise[C_LOCK]) cause_d = cause_t'(1) << C_LOCK;
    else                   cause_d = cause_q;
    cause_en = |rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '1;
      cause_q <= cause_t'(1) << C_AON;
    end else begin
      prev_q <= lvl;
      if (cause_en) cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= cause_q;
  end

  assign rd_data = rd_q;

  // R6
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cause_q & ~(cause_t'(1) << C_OPT)));
  // R8
  opt_keeps_orig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q[C_OPT]) |-> $countones(cause_q) == 2);
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rd_data));
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
  import rstgen_pkg::*;
#(
  parameter int STRETCH     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              aon_rst_n,
  input  logic              core_fail,
  input  logic              ext_rst_n,
  input  logic              wdog_expire,
  input  logic              sw_rst_req,
  input  logic              optbyte_fail,
  input  logic              cpu_lockup,
  input  logic              dsleep_hold,
  input  logic              lv_pwr_good,
  input  logic              dap_rst_req,
  input  logic              rd_en,
  output logic              por_rst_n,
  output logic              sys_rst_n,
  output logic              dap_rst_n,
  output logic [NCAUSE-1:0] rd_data
);
  localparam int NASYNC = 2;

  logic [NASYNC-1:0] a_raw;
  logic [NASYNC-1:0] a_sync;
  logic              dom_arst_n;
  logic              por_req;
  logic              sleep_q;
  logic              sleep_d;
  logic              sleep_lvl;
  logic [NDOM-1:0]   dom_req;
  logic [NDOM-1:0]   dom_rst_n;
  cause_t            lvl;

  assign a_raw      = {~ext_rst_n, core_fail};
  assign dom_arst_n = aon_rst_n & ~(|a_raw);

  for (genvar g = 0; g < NASYNC; g++) begin : g_sync
    rstgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (aon_rst_n & ~a_raw[g]),
      .req_s  (a_sync[g])
    );
  end

  always_comb begin
    sleep_d   = dsleep_hold | (sleep_q & ~lv_pwr_good);
    sleep_lvl = dsleep_hold | sleep_q;
    por_req   = |a_sync;
    dom_req[D_POR] = por_req;
    dom_req[D_SYS] = por_req | wdog_expire | sw_rst_req | optbyte_fail | sleep_lvl;
    dom_req[D_DAP] = por_req | dap_rst_req;
  end

  always_ff @(posedge clk or negedge aon_rst_n) begin
    if (!aon_rst_n) sleep_q <= 1'b0;
    else            sleep_q <= sleep_d;
  end

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    rstgen_stretch #(.STRETCH(STRETCH)) u_str (
      .clk    (clk),
      .arst_n (dom_arst_n),
      .req    (dom_req[d]),
      .rst_n  (dom_rst_n[d])
    );
  end

  assign por_rst_n = dom_rst_n[D_POR];
  assign sys_rst_n = dom_rst_n[D_SYS];
  assign dap_rst_n = dom_rst_n[D_DAP];

  always_comb begin
    lvl         = '0;
    lvl[C_CORE] = a_sync[0];
    lvl[C_PIN]  = a_sync[1];
    lvl[C_WDOG] = wdog_expire;
    lvl[C_SW]   = sw_rst_req;
    lvl[C_WAKE] = sleep_lvl;
    lvl[C_OPT]  = optbyte_fail;
    lvl[C_LOCK] = cpu_lockup;
  end

  rstgen_cause u_cause (
    .clk     (clk),
    .rst_n   (aon_rst_n),
    .lvl     (lvl),
    .rd_en   (rd_en),
    .rd_data (rd_data)
  );

  // R2
  por_covers_all_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
    !por_rst_n |-> !sys_rst_n && !dap_rst_n);
  // R10
  sleep_holds_sys_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
    $past(dsleep_hold) |-> !sys_rst_n);
  // R5
  dap_only_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
    $past(dap_rst_req) && por_rst_n |-> !dap_rst_n);
endmodule

// File: tb/tb_rstgen_top.sv
module tb_rstgen_top;
  localparam int CLK_PERIOD = 10;
  localparam int STR = 16;

  logic clk = 1'b0;
  logic aon_rst_n, core_fail, ext_rst_n, wdog_expire, sw_rst_req, optbyte_fail;
  logic cpu_lockup, dsleep_hold, lv_pwr_good, dap_rst_req, rd_en;
  logic por_rst_n, sys_rst_n, dap_rst_n;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  rstgen_top dut (
    .clk(clk), .aon_rst_n(aon_rst_n), .core_fail(core_fail), .ext_rst_n(ext_rst_n),
    .wdog_expire(wdog_expire), .sw_rst_req(sw_rst_req), .optbyte_fail(optbyte_fail),
    .cpu_lockup(cpu_lockup), .dsleep_hold(dsleep_hold), .lv_pwr_good(lv_pwr_good),
    .dap_rst_req(dap_rst_req), .rd_en(rd_en), .por_rst_n(por_rst_n),
    .sys_rst_n(sys_rst_n), .dap_rst_n(dap_rst_n), .rd_data(rd_data));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt[3];
  bit [1:0] m_core, m_pin;
  bit m_sleep;
  bit [7:0] m_prev, m_cause, m_rd;

  always @(posedge clk or negedge aon_rst_n) begin
    if (!aon_rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_core = 2'b11; m_pin = 2'b11; m_sleep = 0;
      m_prev = 8'hff; m_cause = 8'h01; m_rd = 8'h00;
    end else begin
      bit cs, ps, sl, pr;
      bit [7:0] lv, rise;
      bit [2:0] req;
      cs = core_fail | m_core[1];
      ps = !ext_rst_n | m_pin[1];
      sl = dsleep_hold | m_sleep;
      pr = cs | ps;
      req[0] = pr;
      req[1] = pr | wdog_expire | sw_rst_req | optbyte_fail | sl;
      req[2] = pr | dap_rst_req;
      lv = {cpu_lockup, optbyte_fail, sl, sw_rst_req, wdog_expire, ps, cs, 1'b0};
      rise = lv & ~m_prev;
      if (rd_en) m_rd = m_cause;
      if      (rise[1]) m_cause = 8'h02;
      else if (rise[2]) m_cause = 8'h04;
      else if (rise[3]) m_cause = 8'h08;
      else if (rise[4]) m_cause = 8'h10;
      else if (rise[5]) m_cause = 8'h20;
      else if (rise[6]) m_cause = m_cause | 8'h40;
      else if (rise[7]) m_cause = 8'h80;
      for (int i = 0; i < 3; i++)
        if (req[i]) m_cnt[i] = 0; else if (m_cnt[i] < STR) m_cnt[i]++;
      m_core = core_fail ? 2'b11 : {m_core[0], 1'b0};
      m_pin  = !ext_rst_n ? 2'b11 : {m_pin[0], 1'b0};
      m_sleep = dsleep_hold | (m_sleep & ~lv_pwr_good);
      m_prev = lv;
    end
  end

  always @(negedge clk) begin
    bit aok;
    aok = aon_rst_n && !core_fail && ext_rst_n;
    if (!done) begin
      chk({cur, " por"}, {7'd0, por_rst_n}, {7'd0, aok && m_cnt[0] == STR});
      chk({cur, " sys"}, {7'd0, sys_rst_n}, {7'd0, aok && m_cnt[1] == STR});
      chk({cur, " dap"}, {7'd0, dap_rst_n}, {7'd0, aok && m_cnt[2] == STR});
      chk({cur, " rd"}, rd_data, m_rd);
    end
  end

  task automatic nedge(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic read_cause(output logic [7:0] v);
    nedge(1); rd_en = 1;
    nedge(1); rd_en = 0;
    v = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    aon_rst_n = 1; core_fail = 0; ext_rst_n = 1; wdog_expire = 0; sw_rst_req = 0;
    optbyte_fail = 0; cpu_lockup = 0; dsleep_hold = 0; lv_pwr_good = 1;
    dap_rst_req = 0; rd_en = 0;
    #1 aon_rst_n = 0;
    cur = "R1";
    nedge(3);
    chk("R1 reset outputs", {5'd0, por_rst_n, sys_rst_n, dap_rst_n}, 8'h00);
    chk("R1 reset rd_data", rd_data, 8'h00);
    aon_rst_n = 1;
    cur = "R4";
    nedge(17);
    chk("R4 por held at 17", {7'd0, por_rst_n}, 8'h00);
    nedge(1);
    chk("R4 por released at 18", {7'd0, por_rst_n}, 8'h01);
    read_cause(v); chk("R1 cause after aon", v, 8'h01);

    cur = "R3";
    wdog_expire = 1; nedge(1); wdog_expire = 0;
    chk("R3 wdog sys/por/dap", {5'd0, por_rst_n, sys_rst_n, dap_rst_n}, 8'h05);
    nedge(20); read_cause(v); chk("R6 wdog cause", v, 8'h08);
    sw_rst_req = 1; nedge(1); sw_rst_req = 0;
    chk("R3 sw sys only", {5'd0, por_rst_n, sys_rst_n, dap_rst_n}, 8'h05);
    nedge(20); read_cause(v); chk("R6 sw cause", v, 8'h10);

    cur = "R8";
    optbyte_fail = 1; nedge(1); optbyte_fail = 0;
    chk("R3 opt sys only", {5'd0, por_rst_n, sys_rst_n, dap_rst_n}, 8'h05);
    nedge(20); read_cause(v); chk("R8 opt keeps sw", v, 8'h50);
    wdog_expire = 1; nedge(1); wdog_expire = 0;
    nedge(20); read_cause(v); chk("R6 new event clears opt", v, 8'h08);

    cur = "R9";
    cpu_lockup = 1; nedge(3);
    chk("R9 lockup no reset", {5'd0, por_rst_n, sys_rst_n, dap_rst_n}, 8'h07);
    read_cause(v); chk("R9 lockup cause", v, 8'h80);
    cpu_lockup = 0; nedge(2);

    cur = "R7";
    wdog_expire = 1; sw_rst_req = 1; optbyte_fail = 1; nedge(1);
    wdog_expire = 0; sw_rst_req = 0; optbyte_fail = 0;
    nedge(20); read_cause(v); chk("R7 wdog beats sw and opt", v, 8'h08);
    ext_rst_n = 0; wdog_expire = 1; nedge(1); wdog_expire = 0; ext_rst_n = 1;
    nedge(22); read_cause(v); chk("R7 pin beats wdog", v, 8'h04);

    cur = "R2";
    nedge(1); core_fail = 1; #1;
    chk("R2 core async assert", {5'd0, por_rst_n, sys_rst_n, dap_rst_n}, 8'h00);
    nedge(3); core_fail = 0;
    nedge(17); chk("R4 core por held 17", {7'd0, por_rst_n}, 8'h00);
    nedge(1);  chk("R4 core por released 18", {7'd0, por_rst_n}, 8'h01);
    read_cause(v); chk("R6 core cause", v, 8'h02);
    nedge(1); ext_rst_n = 0; #1;
    chk("R2 pin async assert", {5'd0, por_rst_n, sys_rst_n, dap_rst_n}, 8'h00);
    nedge(2); ext_rst_n = 1; nedge(20);
    read_cause(v); chk("R6 pin cause", v, 8'h04);

    cur = "R5";
    dap_rst_req = 1; nedge(1); dap_rst_req = 0;
    chk("R5 dap only", {5'd0, por_rst_n, sys_rst_n, dap_rst_n}, 8'h06);
    nedge(20);

    cur = "R10";
    dsleep_hold = 1; lv_pwr_good = 0; nedge(5); dsleep_hold = 0;
    nedge(30); chk("R10 held until power good", {7'd0, sys_rst_n}, 8'h00);
    lv_pwr_good = 1;
    nedge(16); chk("R10 sys held 16", {7'd0, sys_rst_n}, 8'h00);
    nedge(1);  chk("R10 sys released 17", {7'd0, sys_rst_n}, 8'h01);
    read_cause(v); chk("R6 wake cause", v, 8'h20);
    wdog_expire = 1; nedge(1); wdog_expire = 0; nedge(20);

    cur = "R11";
    dsleep_hold = 1; nedge(4); dsleep_hold = 0;
    nedge(16); chk("R11 emulated held 16", {7'd0, sys_rst_n}, 8'h00);
    nedge(1);  chk("R11 emulated released 17", {7'd0, sys_rst_n}, 8'h01);
    chk("R11 por untouched", {7'd0, por_rst_n}, 8'h01);

    cur = "R12";
    read_cause(v); chk("R12 read wake", v, 8'h20);
    sw_rst_req = 1; nedge(1); sw_rst_req = 0; nedge(20);
    chk("R12 rd_data holds", rd_data, 8'h20);
    read_cause(v); chk("R12 read new", v, 8'h10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule